// File: doc/BRIEF.md
# Serial Baud and Port Controller

This block is a memory-mapped control unit that sits beside an asynchronous UART with ×64 oversampling. A single 8-bit control register, written through a chip-select and write strobe, holds four settings. Two 3-bit fields set the transmit and receive rates. One bit picks whether the UART talks to the RS423 line drivers or to the cassette interface. The top bit drives the cassette motor relay.

Timing comes from the system clock, nominally 16 MHz. A reloadable 4-bit prescaler divides it by 13 by default, which gives about 1.2308 MHz. Two independent power-of-two dividers turn the prescaled tick into single-cycle baud enable pulses for the UART. A third divider, fixed at /1024, produces the cassette tone enable of about 1202 Hz. A combinational multiplexer steers the UART's serial data and handshake lines to the selected port. It holds the unselected outputs idle and gives the UART fixed "ready" levels where the selected port has no such line.

Top module: `serial_baud_ctrl`

## Requirements
- R1: After reset the control register is 0x00. The motor output is 0, the cassette path is selected, and both rate fields are at code 000.
- R2: The register loads `wdata_i` on a rising clock edge where `cs_i` and `we_i` are both 1. A strobe with either of them at 0 leaves every output as it was.
- R3: `motor_o` follows register bit 7, and 1 turns the motor on.
- R4: Register bit 6 picks the port. With 0 (cassette): `cas_txd_o`=`uart_txd_i`, `uart_rxd_o`=`cas_rxd_i`, `uart_dcd_no`=`cas_dcd_ni`, `uart_cts_no`=0, and `rs_txd_o`=`rs_rts_no`=1. With 1 (RS423): `rs_txd_o`=`uart_txd_i`, `rs_rts_no`=`uart_rts_ni`, `uart_rxd_o`=`rs_rxd_i`, `uart_cts_no`=`rs_cts_ni`, `uart_dcd_no`=0, and `cas_txd_o`=1.
- R5: The prescaler divides the clock by 16 − `PRESCALE_LOAD`, where the load is in the range 0..7. The default load is 3, which gives /13, and a load of 7 gives /9.
- R6: Register bits 2:0 set the transmit enable period to P×N clocks, where P is the prescale ratio. N depends on the code: 000→1 (19200 baud), 100→2 (9600), 010→4 (4800), 110→8 (2400), 001→16 (1200), 101→64 (300), 011→128 (150), 111→256 (75). Each pulse is one clock wide.
- R7: Register bits 5:3 set the receive enable period with the same encoding, independently of the transmit field.
- R8: `tone_en_o` pulses for one clock every P×1024 clocks. Register writes do not disturb it.
- R9: Each accepted write restarts both baud dividers. The first pulse after the write edge is seen between (N−1)×P and N×P−1 cycles later, counted from the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register select |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Register write data |
| tx_en_o | output | 1 | Transmit ×64 baud enable pulse |
| rx_en_o | output | 1 | Receive ×64 baud enable pulse |
| tone_en_o | output | 1 | Cassette tone clock enable pulse |
| motor_o | output | 1 | Cassette motor relay drive |
| uart_txd_i | input | 1 | UART serial output |
| uart_rts_ni | input | 1 | UART request-to-send, active low |
| uart_rxd_o | output | 1 | UART serial input |
| uart_cts_no | output | 1 | UART clear-to-send, active low |
| uart_dcd_no | output | 1 | UART carrier detect, active low |
| rs_txd_o | output | 1 | RS423 transmit data |
| rs_rts_no | output | 1 | RS423 request-to-send, active low |
| rs_rxd_i | input | 1 | RS423 receive data |
| rs_cts_ni | input | 1 | RS423 clear-to-send, active low |
| cas_txd_o | output | 1 | Cassette transmit data |
| cas_rxd_i | input | 1 | Cassette receive data |
| cas_dcd_ni | input | 1 | Cassette carrier detect, active low |

## Verification
The register bits reach `motor_o` and the port multiplexer one edge after the write, and the multiplexer itself has no delay. The bench therefore checks these outputs in the half cycle after that edge, and the routing outputs a moment after it changes the port inputs.

Baud pulses depend on when the prescaler ticks. For each rate pair, the driver queues the restart window and two full periods for each channel before the write edge. A monitor samples at the falling edge, stamps every pulse with a cycle count and pops the queue entry that belongs to it. The tone period is measured the same way from pulse to pulse, and a second instance with load 7 is measured the same way.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef struct packed {
    logic       motor;
    logic       rs_sel;
    logic [2:0] rx_rate;
    logic [2:0] tx_rate;
  } ctrl_t;

  // rate code -> log2 of divide ratio after prescaler
  function automatic logic [3:0] rate_shift(input logic [2:0] code);
    case (code)
      3'b000:  rate_shift = 4'd0;
      3'b100:  rate_shift = 4'd1;
      3'b010:  rate_shift = 4'd2;
      3'b110:  rate_shift = 4'd3;
      3'b001:  rate_shift = 4'd4;
      3'b101:  rate_shift = 4'd6;
      3'b011:  rate_shift = 4'd7;
      default: rate_shift = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sbc_prescaler.sv
module sbc_prescaler #(
  parameter logic [3:0] LOAD = 4'd3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [3:0] cnt_q;

  assign tick_o = (cnt_q == 4'hF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= LOAD;
    else if (tick_o) cnt_q <= LOAD;
    else             cnt_q <= cnt_q + 4'd1;
  end

  // R5: ratio of at least 9 keeps ticks apart
  a_r5_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/sbc_tick_div.sv
module sbc_tick_div #(
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [SW-1:0] shift_i,
  output logic          pulse_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   lim_full;
  logic [CW:0]   lim;

  assign lim_full = (CW+1)'(1) << shift_i;
  assign lim      = lim_full - (CW+1)'(1);
  assign pulse_o  = tick_i && (cnt_q == lim[CW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (pulse_o)   cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CW'(1);
  end

  // R6/R7: enables are single-cycle
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/sbc_port_mux.sv
module sbc_port_mux (
  input  logic rs_sel_i,
  input  logic uart_txd_i,
  input  logic uart_rts_ni,
  output logic uart_rxd_o,
  output logic uart_cts_no,
  output logic uart_dcd_no,
  output logic rs_txd_o,
  output logic rs_rts_no,
  input  logic rs_rxd_i,
  input  logic rs_cts_ni,
  output logic cas_txd_o,
  input  logic cas_rxd_i,
  input  logic cas_dcd_ni
);
  // unselected outputs idle at mark / inactive
  always_comb begin
    if (rs_sel_i) begin
      rs_txd_o    = uart_txd_i;
      rs_rts_no   = uart_rts_ni;
      cas_txd_o   = 1'b1;
      uart_rxd_o  = rs_rxd_i;
      uart_cts_no = rs_cts_ni;
      uart_dcd_no = 1'b0;
    end else begin
      rs_txd_o    = 1'b1;
      rs_rts_no   = 1'b1;
      cas_txd_o   = uart_txd_i;
      uart_rxd_o  = cas_rxd_i;
      uart_cts_no = 1'b0;
      uart_dcd_no = cas_dcd_ni;
    end
  end
endmodule

// File: rtl/serial_baud_ctrl.sv
module serial_baud_ctrl #(
  parameter logic [3:0] PRESCALE_LOAD = 4'd3,
  parameter int         BAUD_CW       = 8,
  parameter int         TONE_SHIFT    = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic       tx_en_o,
  output logic       rx_en_o,
  output logic       tone_en_o,
  output logic       motor_o,
  input  logic       uart_txd_i,
  input  logic       uart_rts_ni,
  output logic       uart_rxd_o,
  output logic       uart_cts_no,
  output logic       uart_dcd_no,
  output logic       rs_txd_o,
  output logic       rs_rts_no,
  input  logic       rs_rxd_i,
  input  logic       rs_cts_ni,
  output logic       cas_txd_o,
  input  logic       cas_rxd_i,
  input  logic       cas_dcd_ni
);
  import sbc_pkg::*;

  localparam int SW = 4;

  ctrl_t         ctrl_q;
  logic          wr_en;
  logic          pre_tick;
  logic [SW-1:0] shift [2];
  logic [1:0]    baud_en;

  assign wr_en = cs_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_t'(wdata_i);
  end

  sbc_prescaler #(.LOAD(PRESCALE_LOAD)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(pre_tick)
  );

  assign shift[0] = rate_shift(ctrl_q.tx_rate);
  assign shift[1] = rate_shift(ctrl_q.rx_rate);

  for (genvar g = 0; g < 2; g++) begin : g_baud
    sbc_tick_div #(.CW(BAUD_CW), .SW(SW)) u_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (pre_tick),
      .restart_i(wr_en),
      .shift_i  (shift[g]),
      .pulse_o  (baud_en[g])
    );
  end

  assign tx_en_o = baud_en[0];
  assign rx_en_o = baud_en[1];

  sbc_tick_div #(.CW(TONE_SHIFT), .SW(SW)) u_tone (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (pre_tick),
    .restart_i(1'b0),
    .shift_i  (SW'(TONE_SHIFT)),
    .pulse_o  (tone_en_o)
  );

  assign motor_o = ctrl_q.motor;

  sbc_port_mux u_mux (
    .rs_sel_i   (ctrl_q.rs_sel),
    .uart_txd_i (uart_txd_i),
    .uart_rts_ni(uart_rts_ni),
    .uart_rxd_o (uart_rxd_o),
    .uart_cts_no(uart_cts_no),
    .uart_dcd_no(uart_dcd_no),
    .rs_txd_o   (rs_txd_o),
    .rs_rts_no  (rs_rts_no),
    .rs_rxd_i   (rs_rxd_i),
    .rs_cts_ni  (rs_cts_ni),
    .cas_txd_o  (cas_txd_o),
    .cas_rxd_i  (cas_rxd_i),
    .cas_dcd_ni (cas_dcd_ni)
  );

  a_r2_motor_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(motor_o) |-> $past(cs_i && we_i));

  a_r9_tx_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (!tx_en_o || ctrl_q.tx_rate == 3'b000));

  a_r9_rx_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (!rx_en_o || ctrl_q.rx_rate == 3'b000));

  a_r8_tone_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_en_o |-> pre_tick);

endmodule

// File: tb/serial_baud_ctrl_tb_top.sv
module serial_baud_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic uart_txd = 1'b1, uart_rts_n = 1'b1, rs_rxd = 1'b1, rs_cts_n = 1'b1;
  logic cas_rxd = 1'b1, cas_dcd_n = 1'b1;
  logic tx_en, rx_en, tone_en, motor, uart_rxd, uart_cts_n, uart_dcd_n;
  logic rs_txd, rs_rts_n, cas_txd;
  logic tone9, tx9, rx9, mot9, u1, u2, u3, u4, u5, u6;

  int checks = 0, errors = 0, cyc = 0;
  int q_tx[$], q_rx[$];
  int wr_cyc = 0;
  bit pend_tx = 0, pend_rx = 0, seen_tx = 0, seen_rx = 0;
  int lo_tx, hi_tx, lo_rx, hi_rx, last_tx, last_rx;
  bit tone_seen = 0, tone9_seen = 0;
  int tone_last, tone9_last, tone_n = 0, tone9_n = 0;
  bit done = 0;

  localparam int P = 13;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_baud_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .wdata_i(wdata),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .tone_en_o(tone_en), .motor_o(motor),
    .uart_txd_i(uart_txd), .uart_rts_ni(uart_rts_n), .uart_rxd_o(uart_rxd),
    .uart_cts_no(uart_cts_n), .uart_dcd_no(uart_dcd_n), .rs_txd_o(rs_txd),
    .rs_rts_no(rs_rts_n), .rs_rxd_i(rs_rxd), .rs_cts_ni(rs_cts_n),
    .cas_txd_o(cas_txd), .cas_rxd_i(cas_rxd), .cas_dcd_ni(cas_dcd_n));

  serial_baud_ctrl #(.PRESCALE_LOAD(4'd7)) dut9_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(1'b0), .we_i(1'b0), .wdata_i(8'h00),
    .tx_en_o(tx9), .rx_en_o(rx9), .tone_en_o(tone9), .motor_o(mot9),
    .uart_txd_i(1'b1), .uart_rts_ni(1'b1), .uart_rxd_o(u1),
    .uart_cts_no(u2), .uart_dcd_no(u3), .rs_txd_o(u4),
    .rs_rts_no(u5), .rs_rxd_i(1'b1), .rs_cts_ni(1'b1),
    .cas_txd_o(u6), .cas_rxd_i(1'b1), .cas_dcd_ni(1'b1));

  function automatic int div_of(input int code);
    int baud;
    case (code)
      0: baud = 19200; 4: baud = 9600; 2: baud = 4800; 6: baud = 2400;
      1: baud = 1200;  5: baud = 300;  3: baud = 150;  default: baud = 75;
    endcase
    return 19200 / baud;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (pend_tx) begin
          chk(cyc - wr_cyc >= lo_tx && cyc - wr_cyc <= hi_tx, "R9 tx first", cyc - wr_cyc, hi_tx);
          pend_tx = 0; seen_tx = 1;
        end else if (!seen_tx) seen_tx = 1;
        else if (q_tx.size() > 0) begin
          int e;
          e = q_tx.pop_front();
          chk(cyc - last_tx == e, "R6 tx period", cyc - last_tx, e);
        end
        last_tx = cyc;
      end
      if (rx_en) begin
        if (pend_rx) begin
          chk(cyc - wr_cyc >= lo_rx && cyc - wr_cyc <= hi_rx, "R9 rx first", cyc - wr_cyc, hi_rx);
          pend_rx = 0; seen_rx = 1;
        end else if (!seen_rx) seen_rx = 1;
        else if (q_rx.size() > 0) begin
          int e;
          e = q_rx.pop_front();
          chk(cyc - last_rx == e, "R7 rx period", cyc - last_rx, e);
        end
        last_rx = cyc;
      end
      if (tone_en) begin
        if (tone_seen && tone_n < 4) begin
          chk(cyc - tone_last == P * 1024, "R8 tone period", cyc - tone_last, P * 1024);
          tone_n++;
        end
        tone_seen = 1; tone_last = cyc;
      end
      if (tone9) begin
        if (tone9_seen && tone9_n < 2) begin
          chk(cyc - tone9_last == 9 * 1024, "R5 load7 tone period", cyc - tone9_last, 9 * 1024);
          tone9_n++;
        end
        tone9_seen = 1; tone9_last = cyc;
      end
    end
  end

  task automatic write_reg(input logic [7:0] v, input logic c, input logic w);
    @(negedge clk); #1;
    if (c && w) begin
      int ntx, nrx;
      ntx = div_of(int'(v[2:0]));
      nrx = div_of(int'(v[5:3]));
      wr_cyc = cyc + 1;
      lo_tx = (ntx - 1) * P; hi_tx = ntx * P - 1;
      lo_rx = (nrx - 1) * P; hi_rx = nrx * P - 1;
      pend_tx = 1; pend_rx = 1;
      q_tx.delete(); q_rx.delete();
      repeat (2) begin q_tx.push_back(ntx * P); q_rx.push_back(nrx * P); end
    end
    cs = c; we = w; wdata = v;
    @(negedge clk); #1;
    cs = 0; we = 0;
  endtask

  task automatic drain();
    while (q_tx.size() > 0 || q_rx.size() > 0 || pend_tx || pend_rx) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(motor == 0, "R1 motor", motor, 0);
    uart_txd = 0; #1;
    chk(cas_txd == 0 && rs_txd == 1, "R1 cassette selected", cas_txd, 0);
    uart_txd = 1;
    repeat (2) begin q_tx.push_back(P); q_rx.push_back(P); end
    drain();

    // R3 motor, R4 RS423 routing
    write_reg(8'hC0, 1, 1);
    chk(motor == 1, "R3 motor on", motor, 1);
    drain();
    uart_txd = 0; uart_rts_n = 0; rs_rxd = 0; rs_cts_n = 0; cas_rxd = 1; #1;
    chk(rs_txd == 0 && cas_txd == 1, "R4 rs txd", rs_txd, 0);
    chk(rs_rts_n == 0 && uart_cts_n == 0, "R4 rs handshake", rs_rts_n, 0);
    chk(uart_rxd == 0 && uart_dcd_n == 0, "R4 rs rxd", uart_rxd, 0);
    uart_txd = 1; uart_rts_n = 1; rs_rxd = 1; rs_cts_n = 1; cas_rxd = 0; #1;
    chk(uart_rxd == 1 && uart_cts_n == 1 && rs_rts_n == 1, "R4 rs follow", uart_rxd, 1);

    // R2 ignored strobes
    @(negedge clk); #1; cs = 0; we = 1; wdata = 8'h00;
    @(negedge clk); #1; cs = 1; we = 0;
    @(negedge clk); #1; cs = 0; we = 0;
    @(negedge clk); #1;
    chk(motor == 1, "R2 no-cs write ignored", motor, 1);
    chk(rs_txd == 1 && cas_txd == 1 && uart_rxd == 1, "R2 port kept", uart_rxd, 1);

    // R4 cassette routing, R3 motor off
    write_reg(8'h00, 1, 1);
    chk(motor == 0, "R3 motor off", motor, 0);
    drain();
    cas_rxd = 0; cas_dcd_n = 0; uart_txd = 0; uart_rts_n = 0; #1;
    chk(uart_rxd == 0 && uart_dcd_n == 0 && uart_cts_n == 0, "R4 cas rx", uart_rxd, 0);
    chk(cas_txd == 0 && rs_txd == 1 && rs_rts_n == 1, "R4 cas tx", cas_txd, 0);
    cas_rxd = 1; cas_dcd_n = 1; uart_txd = 1; uart_rts_n = 1; #1;
    chk(uart_dcd_n == 1 && cas_txd == 1, "R4 cas follow", uart_dcd_n, 1);

    // R6/R7/R9 every code, tx and rx paired differently
    for (int c = 0; c < 8; c++) begin
      write_reg({2'b01, 3'(7 - c), 3'(c)}, 1, 1);
      drain();
    end

    while (tone_n < 4 || tone9_n < 2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule